// File: doc/BRIEF.md
# Audio Serial Transmitter With Underrun Handling

This block takes 32-bit words from a host over a valid/ready handshake, keeps one of them in a single holding slot, and shifts audio samples out on a serial data line. It is paced by an external frame generator that supplies three signals: a bit strobe, a slot-first marker and the channel number of the current slot. A three-bit length code selects the sample width. Two compact codes pack a left and a right sample into one word. A mono switch sends one sample on both channels of a stereo pair.

A new word is needed at the start of a slot. If none is waiting, the transmitter has an underrun. It then sends either the previous word again or zeros, depending on a repeat switch. It also raises sticky flags, one per channel and one global. Software can force these flags on or off with bit-mask strobes. A single interrupt line combines "holding slot empty" and "underrun", each gated by its own mask bit.

The shifter runs a three-state machine: `SH_IDLE` (disabled or flushed), `SH_ARMED` (enabled, waiting for the first slot), `SH_SHIFT` (inside slots). The transitions are:

- `SH_IDLE -> SH_ARMED` when no flush is pending.
- `SH_ARMED -> SH_SHIFT` on a slot start.
- Any state `-> SH_IDLE` on a flush.

The holding slot uses a two-state machine: `HB_EMPTY -> HB_FULL` on an accepted write, `HB_FULL -> HB_EMPTY` on a consume, and any state `-> HB_EMPTY` on a flush. A flush is a soft-reset pulse or `tx_en` low.

Top module: `aud_ser_tx`

## Requirements
- R1: The length code maps 0→32, 1→24, 2→20, 3→18, 4→16, 5→16 packed, 6→8, 7→8 packed. A non-packed sample is taken from word bits [L-1:0]. It is sent MSB first, left-aligned in the slot, and the bits after the sample are driven low.
- R2: With code 5 and mono off, an even channel consumes a word and sends bits 15:0. The following odd channel sends bits 31:16 of that same word and consumes nothing.
- R3: With code 7 and mono off, an even channel consumes a word and sends bits 7:0. The following odd channel sends bits 15:8 of that word.
- R4: With mono on, only even channels consume a word. The odd channel that follows resends the even channel's sample; in packed codes this is the low half.
- R5: If a slot needs a word and the holding slot is empty, the slot sends the previous word's sample when `repeat_last`=1, and zero when `repeat_last`=0.
- R6: An underrun sets the global flag and the flag of the channel whose slot needed the word. In mono or packed mode the flag of the odd partner channel is also set. Flags stay set until cleared.
- R7: Each bit set in `ur_set` forces that channel flag on, and each bit set in `ur_clr` forces it off; set wins over clear. `ur_glb_set` and `ur_glb_clr` do the same for the global flag.
- R8: `wr_ready` is high exactly when the transmitter is enabled, not in soft reset, and the single holding slot is empty. An accepted write makes it low.
- R9: Interrupt mask bit 0 gates ready and bit 1 gates the global underrun flag. `irq_en_set` and `irq_en_clr` set and clear mask bits, and set wins. `irq` is the OR of the gated terms.
- R10: A soft-reset pulse or `tx_en` low empties the holding slot, clears the current word, the flags and the shift register, and holds `sd_out` low. The interrupt mask survives this.
- R11: A slot starts when `bit_stb` and `slot_first` are both high while the transmitter is enabled. The sample's MSB appears on `sd_out` one clock later, and each later `bit_stb` advances by one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable level |
| soft_rst | input | 1 | Soft reset pulse |
| len_code | input | 3 | Sample length code |
| mono | input | 1 | One sample per stereo pair |
| repeat_last | input | 1 | Underrun sends previous word instead of zero |
| bit_stb | input | 1 | One serial bit period elapses |
| slot_first | input | 1 | This bit is the first of a slot |
| slot_ch | input | 3 | Channel number of the slot |
| wr_valid | input | 1 | Host word valid |
| wr_data | input | 32 | Host word |
| wr_ready | output | 1 | Holding slot can take a word |
| ur_set | input | 8 | Per-channel flag set mask |
| ur_clr | input | 8 | Per-channel flag clear mask |
| ur_glb_set | input | 1 | Global flag set |
| ur_glb_clr | input | 1 | Global flag clear |
| irq_en_set | input | 2 | Interrupt mask set (bit0 ready, bit1 underrun) |
| irq_en_clr | input | 2 | Interrupt mask clear |
| sd_out | output | 1 | Serial data |
| ur_ch | output | 8 | Sticky per-channel underrun flags |
| ur_glb | output | 1 | Sticky global underrun flag |
| irq | output | 1 | Interrupt |

## Verification
The bench sweeps every length code against both mono settings and both repeat settings. Each configuration runs a left/right/left/right slot sequence with a deliberately missing word on the third slot. Each captured slot is compared with a sample computed from the word arithmetically. This separates the packed halves from plain truncation, shows whether mono pairs consume a word only once, and shows whether an underrun repeats the previous word or sends zero. Directed patterns then cover the following:

- an underrun on a high channel, which flags a single bit;
- a packed underrun, which flags a channel pair;
- simultaneous set and clear strobes;
- the interrupt masks;
- a disable that discards a pending word;
- the disabled line staying low.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 6;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_ARMED = 2'd1,
        SH_SHIFT = 2'd2
    } sh_state_e;

    typedef enum logic {
        HB_EMPTY = 1'b0,
        HB_FULL  = 1'b1
    } hb_state_e;

    // Sample length in bits for a length code
    function automatic logic [LEN_W-1:0] len_of(input logic [2:0] code);
        logic [LEN_W-1:0] l;
        case (code)
            3'd0:    l = 6'd32;
            3'd1:    l = 6'd24;
            3'd2:    l = 6'd20;
            3'd3:    l = 6'd18;
            3'd4:    l = 6'd16;
            3'd5:    l = 6'd16;
            default: l = 6'd8;
        endcase
        return l;
    endfunction

    // Codes that pack two samples in one word
    function automatic logic is_packed(input logic [2:0] code);
        return (code == 3'd5) || (code == 3'd7);
    endfunction

endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf
    import aud_tx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         wr_ready,
    output logic         full,
    output logic [W-1:0] hold_q
);

    hb_state_e st, st_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= HB_EMPTY;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            HB_EMPTY: if (wr_valid) st_n = HB_FULL;
            HB_FULL:  if (take)     st_n = HB_EMPTY;
        endcase
        if (flush) st_n = HB_EMPTY;
    end

    // outputs
    always_comb begin
        wr_ready = !flush && (st == HB_EMPTY);
        full     = (st == HB_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   hold_q <= '0;
        else if (flush)               hold_q <= '0;
        else if (wr_valid && wr_ready) hold_q <= wr_data;
    end

    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready); // R8

endmodule

// File: rtl/tx_word_pick.sv
module tx_word_pick
    import aud_tx_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              slot_go,
    input  logic [CH_W-1:0]   slot_ch,
    input  logic [2:0]        len_code,
    input  logic              mono,
    input  logic              repeat_last,
    input  logic              hold_full,
    input  logic [WORD_W-1:0] hold_data,
    output logic              take,
    output logic [NCH-1:0]    ur_mask,
    output logic [WORD_W-1:0] sample
);

    logic [WORD_W-1:0] cur_q, cur_n;
    logic              pk, need, upper;
    logic [LEN_W-1:0]  len;
    logic [2*WORD_W-1:0] ext, shifted, lenmask, aligned;
    logic [CH_W-1:0]   odd_ch;

    always_comb begin
        pk     = is_packed(len_code);
        len    = len_of(len_code);
        need   = !slot_ch[0] || (!mono && !pk);
        take   = slot_go && need;
        odd_ch = {slot_ch[CH_W-1:1], 1'b1};

        cur_n = cur_q;
        if (take) begin
            if (hold_full)         cur_n = hold_data;
            else if (!repeat_last) cur_n = '0;
        end

        ur_mask = '0;
        if (take && !hold_full) begin
            ur_mask[slot_ch] = 1'b1;
            if (mono || pk) ur_mask[odd_ch] = 1'b1;
        end

        upper   = slot_ch[0] && pk && !mono;
        ext     = {{WORD_W{1'b0}}, cur_n};
        shifted = upper ? (ext >> len) : ext;
        lenmask = ({{(2*WORD_W-1){1'b0}}, 1'b1} << len) - 1'b1;
        aligned = (shifted & lenmask) << (7'(WORD_W) - 7'(len));
        sample  = aligned[WORD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cur_q <= '0;
        else if (flush) cur_q <= '0;
        else            cur_q <= cur_n;
    end

    AST_UR_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (|ur_mask) |-> (slot_go && !hold_full)); // R6

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import aud_tx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         bit_stb,
    input  logic         slot_first,
    input  logic [W-1:0] load_val,
    output logic         slot_go,
    output logic         sd_out
);

    sh_state_e st, st_n;
    logic [W-1:0] sh_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SH_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            SH_IDLE:  st_n = SH_ARMED;
            SH_ARMED: if (bit_stb && slot_first) st_n = SH_SHIFT;
            SH_SHIFT: st_n = SH_SHIFT;
            default:  st_n = SH_IDLE;
        endcase
        if (flush) st_n = SH_IDLE;
    end

    // outputs
    always_comb begin
        slot_go = (st != SH_IDLE) && !flush && bit_stb && slot_first;
        sd_out  = sh_q[W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           sh_q <= '0;
        else if (flush)                       sh_q <= '0;
        else if (slot_go)                     sh_q <= load_val;
        else if (bit_stb && st == SH_SHIFT)   sh_q <= {sh_q[W-2:0], 1'b0};
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !sd_out); // R10

    AST_MSB_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        slot_go |=> (sd_out == $past(load_val[W-1]))); // R11

endmodule

// File: rtl/tx_ur_flags.sv
module tx_ur_flags #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush,
    input  logic [NCH-1:0] hw_mask,
    input  logic [NCH-1:0] sw_set,
    input  logic [NCH-1:0] sw_clr,
    input  logic           glb_set,
    input  logic           glb_clr,
    input  logic [1:0]     irq_en_set,
    input  logic [1:0]     irq_en_clr,
    input  logic           ready,
    output logic [NCH-1:0] ur_ch,
    output logic           ur_glb,
    output logic           irq
);

    logic [1:0] msk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msk_q  <= '0;
            ur_ch  <= '0;
            ur_glb <= 1'b0;
        end else begin
            msk_q <= (msk_q & ~irq_en_clr) | irq_en_set;
            if (flush) begin
                ur_ch  <= '0;
                ur_glb <= 1'b0;
            end else begin
                ur_ch  <= (ur_ch & ~sw_clr) | sw_set | hw_mask;
                ur_glb <= (ur_glb & ~glb_clr) | glb_set | (|hw_mask);
            end
        end
    end

    always_comb irq = (msk_q[0] && ready) || (msk_q[1] && ur_glb);

    AST_HW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hw_mask) && !flush) |=> ur_glb); // R6

    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((&sw_clr) && (sw_set == '0) && (hw_mask == '0)) |=> (ur_ch == '0)); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !ur_glb) |-> !irq); // R9

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
    import aud_tx_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              soft_rst,
    input  logic [2:0]        len_code,
    input  logic              mono,
    input  logic              repeat_last,
    input  logic              bit_stb,
    input  logic              slot_first,
    input  logic [CH_W-1:0]   slot_ch,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic [NCH-1:0]    ur_set,
    input  logic [NCH-1:0]    ur_clr,
    input  logic              ur_glb_set,
    input  logic              ur_glb_clr,
    input  logic [1:0]        irq_en_set,
    input  logic [1:0]        irq_en_clr,
    output logic              sd_out,
    output logic [NCH-1:0]    ur_ch,
    output logic              ur_glb,
    output logic              irq
);

    logic              flush;
    logic              slot_go, take, hold_full;
    logic [WORD_W-1:0] hold_data, sample;
    logic [NCH-1:0]    ur_mask;

    always_comb flush = soft_rst || !tx_en;

    tx_hold_buf #(.W(WORD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_valid(wr_valid), .wr_data(wr_data), .take(take),
        .wr_ready(wr_ready), .full(hold_full), .hold_q(hold_data)
    );

    tx_word_pick #(.NCH(NCH)) u_pick (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .slot_go(slot_go), .slot_ch(slot_ch), .len_code(len_code),
        .mono(mono), .repeat_last(repeat_last),
        .hold_full(hold_full), .hold_data(hold_data),
        .take(take), .ur_mask(ur_mask), .sample(sample)
    );

    tx_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .bit_stb(bit_stb), .slot_first(slot_first), .load_val(sample),
        .slot_go(slot_go), .sd_out(sd_out)
    );

    tx_ur_flags #(.NCH(NCH)) u_flags (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .hw_mask(ur_mask), .sw_set(ur_set), .sw_clr(ur_clr),
        .glb_set(ur_glb_set), .glb_clr(ur_glb_clr),
        .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr),
        .ready(wr_ready), .ur_ch(ur_ch), .ur_glb(ur_glb), .irq(irq)
    );

endmodule

// File: tb/aud_ser_tx_test.sv
module aud_ser_tx_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, tx_en, soft_rst, mono, repeat_last, bit_stb, slot_first;
    logic [2:0]  len_code, slot_ch;
    logic        wr_valid, wr_ready, ur_glb_set, ur_glb_clr, sd_out, ur_glb, irq;
    logic [31:0] wr_data;
    logic [7:0]  ur_set, ur_clr, ur_ch;
    logic [1:0]  irq_en_set, irq_en_clr;

    int checks = 0;
    int fails  = 0;

    aud_ser_tx uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .soft_rst(soft_rst),
        .len_code(len_code), .mono(mono), .repeat_last(repeat_last),
        .bit_stb(bit_stb), .slot_first(slot_first), .slot_ch(slot_ch),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .ur_set(ur_set), .ur_clr(ur_clr), .ur_glb_set(ur_glb_set),
        .ur_glb_clr(ur_glb_clr), .irq_en_set(irq_en_set),
        .irq_en_clr(irq_en_clr), .sd_out(sd_out), .ur_ch(ur_ch),
        .ur_glb(ur_glb), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_sample(input logic [31:0] w, input int code,
                                                 input bit odd, input bit mo);
        int L;
        bit pk;
        logic [31:0] v;
        L  = (code == 0) ? 32 : (code == 1) ? 24 : (code == 2) ? 20 :
             (code == 3) ? 18 : (code == 4 || code == 5) ? 16 : 8;
        pk = (code == 5) || (code == 7);
        v  = w;
        if (odd && pk && !mo) v = v >> L;
        if (L == 32) return v;
        return (v & ((32'd1 << L) - 32'd1)) << (32 - L);
    endfunction

    // tasks start and end just after a falling edge
    task automatic put_word(input logic [31:0] w);
        chk("R8 ready before write", {31'b0, wr_ready}, 32'd1);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic run_slot(input logic [2:0] ch, output logic [31:0] got);
        bit_stb    = 1'b1;
        slot_first = 1'b1;
        slot_ch    = ch;
        @(negedge clk);
        got[31]    = sd_out;
        slot_first = 1'b0;
        for (int b = 30; b >= 0; b--) begin
            @(negedge clk);
            got[b] = sd_out;
        end
        bit_stb = 1'b0;
    endtask

    task automatic do_soft_reset();
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_idle();
        @(negedge clk);
        ur_set = '0; ur_clr = '0; ur_glb_set = 0; ur_glb_clr = 0;
        irq_en_set = '0; irq_en_clr = '0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] got, mw, w, expf;
        rst_n = 0; tx_en = 0; soft_rst = 0; len_code = 0; mono = 0; repeat_last = 0;
        bit_stb = 0; slot_first = 0; slot_ch = 0; wr_valid = 0; wr_data = 0;
        ur_set = 0; ur_clr = 0; ur_glb_set = 0; ur_glb_clr = 0;
        irq_en_set = 0; irq_en_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R8 reset ready", {31'b0, wr_ready}, 32'd0);
        chk("R10 reset sd", {31'b0, sd_out}, 32'd0);
        chk("R9 reset irq", {31'b0, irq}, 32'd0);
        chk("R6 reset flags", {23'b0, ur_glb, ur_ch}, 32'd0);

        // disabled: line idle low, no word taken, no flags
        run_slot(3'd0, got);
        chk("R10 disabled line", got, 32'd0);
        chk("R10 disabled flags", {23'b0, ur_glb, ur_ch}, 32'd0);

        tx_en = 1;
        @(negedge clk);
        chk("R8 enabled empty ready", {31'b0, wr_ready}, 32'd1);
        irq_en_set = 2'b01;
        pulse_idle();
        chk("R9 ready irq", {31'b0, irq}, 32'd1);
        put_word(32'h1234_5678);
        chk("R8 full not ready", {31'b0, wr_ready}, 32'd0);
        chk("R9 full no irq", {31'b0, irq}, 32'd0);

        // disable discards the pending word
        tx_en = 0;
        @(negedge clk);
        tx_en = 1;
        @(negedge clk);
        chk("R10 hold emptied", {31'b0, wr_ready}, 32'd1);
        irq_en_clr = 2'b01;
        pulse_idle();
        chk("R9 mask cleared", {31'b0, irq}, 32'd0);
        repeat_last = 1;
        run_slot(3'd0, got);
        chk("R10 word cleared on disable", got, 32'd0);
        chk("R6 ch0 flag", {23'b0, ur_glb, ur_ch}, 32'h101);
        irq_en_set = 2'b10;
        pulse_idle();
        chk("R9 underrun irq", {31'b0, irq}, 32'd1);
        irq_en_set = 2'b10; irq_en_clr = 2'b10;
        pulse_idle();
        chk("R9 mask set wins", {31'b0, irq}, 32'd1);
        irq_en_clr = 2'b10;
        pulse_idle();
        chk("R9 underrun masked", {31'b0, irq}, 32'd0);

        // software flag strobes
        do_soft_reset();
        chk("R10 soft reset flags", {23'b0, ur_glb, ur_ch}, 32'd0);
        ur_set = 8'hA5;
        pulse_idle();
        chk("R7 set mask", {24'b0, ur_ch}, 32'hA5);
        ur_clr = 8'h05;
        pulse_idle();
        chk("R7 clear mask", {24'b0, ur_ch}, 32'hA0);
        ur_set = 8'h0F; ur_clr = 8'hFF;
        pulse_idle();
        chk("R7 set wins", {24'b0, ur_ch}, 32'h0F);
        ur_glb_set = 1;
        pulse_idle();
        chk("R7 global set", {31'b0, ur_glb}, 32'd1);
        ur_glb_clr = 1;
        pulse_idle();
        chk("R7 global clear", {31'b0, ur_glb}, 32'd0);
        ur_glb_set = 1; ur_glb_clr = 1;
        pulse_idle();
        chk("R7 global set wins", {31'b0, ur_glb}, 32'd1);

        // single-channel underrun on a high slot
        do_soft_reset();
        repeat_last = 0; len_code = 3'd0; mono = 0;
        run_slot(3'd5, got);
        chk("R5 zero on underrun", got, 32'd0);
        chk("R6 ch5 only", {23'b0, ur_glb, ur_ch}, 32'h120);

        // packed pair on slots 2/3, then pair underrun
        do_soft_reset();
        len_code = 3'd5;
        put_word(32'hBEEF_C0DE);
        run_slot(3'd2, got);
        chk("R2 low half", got, 32'hC0DE_0000);
        run_slot(3'd3, got);
        chk("R2 high half", got, 32'hBEEF_0000);
        chk("R2 odd consumed nothing", {31'b0, wr_ready}, 32'd1);
        run_slot(3'd2, got);
        chk("R5 packed zero", got, 32'd0);
        chk("R6 pair flags", {23'b0, ur_glb, ur_ch}, 32'h10C);

        // timing: MSB and LSB positions
        do_soft_reset();
        len_code = 3'd0;
        put_word(32'h8000_0001);
        run_slot(3'd0, got);
        chk("R11 bit order", got, 32'h8000_0001);

        // sweep all codes x mono x repeat
        for (int cfg = 0; cfg < 32; cfg++) begin
            bit pk, need, mo, rp;
            int code;
            code = cfg >> 2;
            mo   = cfg[1];
            rp   = cfg[0];
            pk   = (code == 5) || (code == 7);
            len_code = 3'(code); mono = mo; repeat_last = rp;
            do_soft_reset();
            mw = 32'd0;
            for (int k = 0; k < 4; k++) begin
                string req;
                bit odd;
                odd  = k[0];
                need = !odd || (!mo && !pk);
                if (need && k != 2) begin
                    w = 32'hA5C3_96E1 ^ (32'(cfg) * 32'h0101_0101) ^ (32'(k) * 32'h1F3D_5B79);
                    put_word(w);
                    mw = w;
                end else if (need && !rp) begin
                    mw = 32'd0;
                end
                run_slot({2'b00, odd}, got);
                if (k == 2)                 req = "R5 sweep underrun";
                else if (code == 5 && !mo)  req = "R2 sweep";
                else if (code == 7 && !mo)  req = "R3 sweep";
                else if (mo && odd)         req = "R4 sweep";
                else                        req = "R1 sweep";
                chk(req, got, model_sample(mw, code, odd, mo));
            end
            expf = (mo || pk) ? 32'h103 : 32'h101;
            chk("R6 sweep flags", {23'b0, ur_glb, ur_ch}, expf);
            do_soft_reset();
            chk("R10 sweep cleared", {23'b0, ur_glb, ur_ch}, 32'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule